// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a scatter-gather list held in memory and turns it into a stream of segments. A walk starts with a one-cycle pulse on `start`, which latches a list base address and a limit on the number of entries. Each list entry is eight bytes long. For every entry the walker makes two 32-bit word reads through a request/response port: first the length word, then the address word. Once both words have arrived it presents one segment (address, length, last flag) on a valid/ready output.

A walk ends in one of three ways. It ends cleanly after the segment of an entry whose length word has its top bit set. It ends with an error when the entry limit is used up before such an entry appears. It also ends with an error at once when a read comes back with an error response. Completion and error are level flags that hold until the next accepted start. A running byte total of all delivered segment lengths is kept next to them.

The walker does not read the data the segments point to, and it does not process that data.

Top module: `sgw_walker`

## Requirements
- R1: After reset `busy`, `done`, `err`, `rd_req_valid` and `seg_valid` are 0 and `byte_total` is 0.
- R2: Entry i is fetched from A + 8*i, where A is `base_addr` with its three low bits forced to zero. The length word is requested at offset 0 before the address word at offset 4. A new request is issued only after the previous response has been taken, and a read request and a segment are never offered in the same cycle.
- R3: A segment carries `seg_len` = length word bits 27:0, `seg_addr` = address word bits 30:0 and `seg_last` = length word bit 31. All other bits of both words are discarded.
- R4: A segment with `seg_last` = 1 ends the walk once it is accepted: `done` rises with `err` = 0 and no further read is requested. This holds even when that entry is also the final one the limit allows.
- R5: If `max_entries` segments are accepted and none of them has `seg_last` set, the walk ends with `done` = 1 and `err` = 1. A start with `max_entries` = 0 ends at once with `done` = 1 and `err` = 1 and issues no read.
- R6: A response with `rd_rsp_err` = 1 ends the walk at once with `done` = 1 and `err` = 1. The entry being fetched yields no segment.
- R7: `rd_req_valid` with `rd_req_addr`, and `seg_valid` with the segment fields, hold steady until the matching ready is seen.
- R8: `byte_total` clears when a start is accepted and grows by `seg_len` on each accepted segment.
- R9: A `start` pulse while `busy` is 1 is ignored. The running walk continues with its own base and limit.
- R10: `done` and `err` keep their values after a walk ends until the next accepted start, which clears them. `err` is never 1 while `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| base_addr | input | ADDR_W | Byte address of entry 0 |
| max_entries | input | CNT_W | Largest number of entries the walk may consume |
| rd_req_valid | output | 1 | Word read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_err | input | 1 | Read response carries an error |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_addr | output | 31 | Segment byte address |
| seg_len | output | 28 | Segment byte length |
| seg_last | output | 1 | Segment came from the entry marked last |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | The most recent walk has ended |
| err | output | 1 | The most recent walk ended by limit or read error |
| byte_total | output | TOT_W | Sum of accepted segment lengths in this walk |

## Verification
The bench builds the walker with ADDR_W = 32, CNT_W = 8 and TOT_W = 32. With an 8-bit limit, the limit values 0, 1, 2, 3, 4 and 8 are all in range. This lets the bench hit a limit below, equal to and above the position of the last marker. The 32-bit total is wide enough to take a length of nearly 2^28 plus several small ones without wrapping, so a dropped or extra length bit shows up in the sum. The memory model stalls requests and segments on unrelated cycle patterns and alternates the response delay, so that the hold and ordering behaviour is exercised under backpressure.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int WORD_W      = 32;
  localparam int SEG_LEN_W   = 28;
  localparam int SEG_ADDR_W  = 31;
  localparam int LAST_POS    = 31;
  localparam int ENTRY_SHIFT = 3;   // eight bytes per entry
  localparam int ADDR_WORD_OFS = 4; // second word of an entry

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_LEN_REQ,
    WS_LEN_WAIT,
    WS_ADR_REQ,
    WS_ADR_WAIT,
    WS_EMIT
  } walk_state_e;

  function automatic logic [SEG_LEN_W-1:0] seg_len_of(input logic [WORD_W-1:0] w);
    return w[SEG_LEN_W-1:0];
  endfunction

  function automatic logic [SEG_ADDR_W-1:0] seg_addr_of(input logic [WORD_W-1:0] w);
    return w[SEG_ADDR_W-1:0];
  endfunction

  function automatic logic is_last(input logic [WORD_W-1:0] w);
    return w[LAST_POS];
  endfunction

endpackage

// File: rtl/sgw_walk_ctrl.sv
module sgw_walk_ctrl
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  max_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              cap_len_o,
  output logic              cap_addr_o,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  input  logic              seg_last_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              start_fire_o,
  output logic              seg_fire_o,
  output logic              rsp_take_o,
  output logic              walk_end_o
);

  function automatic logic [ADDR_W-1:0] align_entry(input logic [ADDR_W-1:0] b);
    return {b[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [CNT_W-1:0]  i,
                                                   input logic              second);
    logic [ADDR_W-1:0] ofs;
    ofs = ADDR_W'(i) << ENTRY_SHIFT;
    return b + ofs + (second ? ADDR_W'(ADDR_WORD_OFS) : '0);
  endfunction

  walk_state_e       st_q, st_d;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  idx_q, max_q;
  logic [CNT_W:0]    idx_inc;
  logic              limit_hit;
  logic              done_q, err_q;
  logic              in_wait;

  assign idx_inc   = {1'b0, idx_q} + {{CNT_W{1'b0}}, 1'b1};
  assign limit_hit = (idx_inc == {1'b0, max_q});
  assign in_wait   = (st_q == WS_LEN_WAIT) || (st_q == WS_ADR_WAIT);

  assign start_fire_o = start_i && (st_q == WS_IDLE);
  assign req_valid_o  = (st_q == WS_LEN_REQ) || (st_q == WS_ADR_REQ);
  assign req_addr_o   = word_addr(base_q, idx_q, st_q == WS_ADR_REQ);
  assign rsp_take_o   = rsp_valid_i && in_wait;
  assign cap_len_o    = rsp_take_o && !rsp_err_i && (st_q == WS_LEN_WAIT);
  assign cap_addr_o   = rsp_take_o && !rsp_err_i && (st_q == WS_ADR_WAIT);
  assign seg_valid_o  = (st_q == WS_EMIT);
  assign seg_fire_o   = seg_valid_o && seg_ready_i;
  assign busy_o       = (st_q != WS_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign walk_end_o   = (start_fire_o && (max_i == '0))
                      || (rsp_take_o && rsp_err_i)
                      || (seg_fire_o && (seg_last_i || limit_hit));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE:     if (start_i && (max_i != '0)) st_d = WS_LEN_REQ;
      WS_LEN_REQ:  if (req_ready_i) st_d = WS_LEN_WAIT;
      WS_LEN_WAIT: if (rsp_valid_i) st_d = rsp_err_i ? WS_IDLE : WS_ADR_REQ;
      WS_ADR_REQ:  if (req_ready_i) st_d = WS_ADR_WAIT;
      WS_ADR_WAIT: if (rsp_valid_i) st_d = rsp_err_i ? WS_IDLE : WS_EMIT;
      WS_EMIT:     if (seg_ready_i) st_d = (seg_last_i || limit_hit) ? WS_IDLE : WS_LEN_REQ;
      default:     st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      base_q <= '0;
      max_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_fire_o) begin
        base_q <= align_entry(base_i);
        max_q  <= max_i;
        idx_q  <= '0;
        done_q <= (max_i == '0);
        err_q  <= (max_i == '0);
      end else begin
        if (seg_fire_o && !walk_end_o) idx_q <= idx_inc[CNT_W-1:0];
        if (walk_end_o) begin
          done_q <= 1'b1;
          err_q  <= !(seg_fire_o && seg_last_i);
        end
      end
    end
  end

endmodule

// File: rtl/sgw_seg_stage.sv
module sgw_seg_stage
  import sgw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_len_i,
  input  logic                  cap_addr_i,
  input  logic [WORD_W-1:0]     word_i,
  output logic [SEG_ADDR_W-1:0] seg_addr_o,
  output logic [SEG_LEN_W-1:0]  seg_len_o,
  output logic                  seg_last_o
);

  logic [WORD_W-1:0] len_word_q, addr_word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_word_q  <= '0;
      addr_word_q <= '0;
    end else begin
      if (cap_len_i)  len_word_q  <= word_i;
      if (cap_addr_i) addr_word_q <= word_i;
    end
  end

  assign seg_len_o  = seg_len_of(len_word_q);
  assign seg_last_o = is_last(len_word_q);
  assign seg_addr_o = seg_addr_of(addr_word_q);

endmodule

// File: rtl/sgw_byte_acc.sv
module sgw_byte_acc #(
  parameter int TOT_W = 32,
  parameter int LEN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [TOT_W-1:0] total_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       total_o <= '0;
    else if (clear_i) total_o <= '0;
    else if (add_i)   total_o <= total_o + TOT_W'(len_i);
  end

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int TOT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     base_addr,
  input  logic [CNT_W-1:0]      max_entries,
  output logic                  rd_req_valid,
  input  logic                  rd_req_ready,
  output logic [ADDR_W-1:0]     rd_req_addr,
  input  logic                  rd_rsp_valid,
  input  logic [31:0]           rd_rsp_data,
  input  logic                  rd_rsp_err,
  output logic                  seg_valid,
  input  logic                  seg_ready,
  output logic [30:0]           seg_addr,
  output logic [27:0]           seg_len,
  output logic                  seg_last,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [TOT_W-1:0]      byte_total
);

  // named internal events, observed by the bound checker
  logic start_fire_w, seg_fire_w, rsp_take_w, walk_end_w;
  logic cap_len_w, cap_addr_w;

  sgw_walk_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .base_i       (base_addr),
    .max_i        (max_entries),
    .req_valid_o  (rd_req_valid),
    .req_ready_i  (rd_req_ready),
    .req_addr_o   (rd_req_addr),
    .rsp_valid_i  (rd_rsp_valid),
    .rsp_err_i    (rd_rsp_err),
    .cap_len_o    (cap_len_w),
    .cap_addr_o   (cap_addr_w),
    .seg_valid_o  (seg_valid),
    .seg_ready_i  (seg_ready),
    .seg_last_i   (seg_last),
    .busy_o       (busy),
    .done_o       (done),
    .err_o        (err),
    .start_fire_o (start_fire_w),
    .seg_fire_o   (seg_fire_w),
    .rsp_take_o   (rsp_take_w),
    .walk_end_o   (walk_end_w)
  );

  sgw_seg_stage stage_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_len_i  (cap_len_w),
    .cap_addr_i (cap_addr_w),
    .word_i     (rd_rsp_data),
    .seg_addr_o (seg_addr),
    .seg_len_o  (seg_len),
    .seg_last_o (seg_last)
  );

  sgw_byte_acc #(.TOT_W(TOT_W), .LEN_W(SEG_LEN_W)) acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_fire_w),
    .add_i   (seg_fire_w),
    .len_i   (seg_len),
    .total_o (byte_total)
  );

endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int TOT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_err,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [30:0]       seg_addr,
  input logic [27:0]       seg_len,
  input logic              seg_last,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [TOT_W-1:0]  byte_total,
  input logic              start_fire,
  input logic              seg_fire,
  input logic              rsp_take
);

  logic [TOT_W-1:0] len_ext;
  assign len_ext = TOT_W'(seg_len);

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && seg_valid)); // R2

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fire && seg_last |=> done && !err && !busy); // R4

  AST_RSP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && rd_rsp_err |=> done && err && !busy && !seg_valid); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R7

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last)); // R7

  AST_TOTAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> byte_total == '0); // R8

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fire |=> byte_total == $past(byte_total) + $past(len_ext)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !seg_valid); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R10

endmodule

bind sgw_walker sgw_walker_chk #(.ADDR_W(ADDR_W), .TOT_W(TOT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_err   (rd_rsp_err),
  .seg_valid    (seg_valid),
  .seg_ready    (seg_ready),
  .seg_addr     (seg_addr),
  .seg_len      (seg_len),
  .seg_last     (seg_last),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .byte_total   (byte_total),
  .start_fire   (start_fire_w),
  .seg_fire     (seg_fire_w),
  .rsp_take     (rsp_take_w)
);

// File: tb/sgw_walker_tb.sv
`timescale 1ns/1ps
module sgw_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [7:0]  max_entries = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [30:0] seg_addr;
  logic [27:0] seg_len;
  logic        seg_last;
  logic        busy, done, err;
  logic [31:0] byte_total;

  always #2 clk = ~clk;

  sgw_walker dut_i (.*);

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mem [0:127];
  logic [31:0] exp_base = '0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int          seg_cnt = 0;
  int          req_cnt = 0;
  logic [31:0] seg_sum = '0;
  int          cyc = 0;
  bit          pend = 1'b0;
  int          pend_dly = 0;
  logic [31:0] pend_addr = '0;

  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  maxe;
    logic [7:0]  nseg;
    logic        eerr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h000, 8'd8, 8'd3, 1'b0},  // R4 list ends on its marker
    '{32'h000, 8'd2, 8'd2, 1'b1},  // R5 limit before marker
    '{32'h000, 8'd3, 8'd3, 1'b0},  // R4 marker on the final allowed entry
    '{32'h040, 8'd8, 8'd1, 1'b0},  // R3 single entry, high address bit dropped
    '{32'h080, 8'd4, 8'd4, 1'b1},  // R5 list without any marker
    '{32'h044, 8'd1, 8'd1, 1'b0},  // R2 unaligned base snaps to 0x040
    '{32'h100, 8'd8, 8'd1, 1'b1}   // R6 read error on second entry
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem[a[8:2]];
  endfunction

  // memory model and stream observer
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rd_rsp_valid = 1'b0;
      rd_rsp_err   = 1'b0;
      if (pend) begin
        if (pend_dly == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = rd_mem(pend_addr);
          rd_rsp_err   = (pend_addr == err_addr);
          pend = 1'b0;
        end else pend_dly--;
      end
      rd_req_ready = (cyc % 4) != 1;
      seg_ready    = (cyc % 3) != 0;
      if (rd_req_valid && rd_req_ready) begin
        // R2: word order length, address, entry after entry
        check(rd_req_addr == exp_base + 32'(4 * req_cnt), "R2 request address",
              64'(rd_req_addr), 64'(exp_base + 32'(4 * req_cnt)));
        req_cnt++;
        pend = 1'b1;
        pend_dly = (req_cnt % 2 == 1) ? 0 : 2;
        pend_addr = rd_req_addr;
      end
      if (seg_valid && seg_ready) begin
        logic [31:0] lw, aw;
        lw = rd_mem(exp_base + 32'(8 * seg_cnt));
        aw = rd_mem(exp_base + 32'(8 * seg_cnt) + 32'd4);
        check(seg_len == lw[27:0], "R3 seg_len", 64'(seg_len), 64'(lw[27:0]));
        check(seg_addr == aw[30:0], "R3 seg_addr", 64'(seg_addr), 64'(aw[30:0]));
        check(seg_last == lw[31], "R3 seg_last", 64'(seg_last), 64'(lw[31]));
        seg_sum = seg_sum + {4'd0, lw[27:0]};
        seg_cnt++;
      end
    end
  end

  task automatic pulse_start(input logic [31:0] b, input logic [7:0] m);
    @(negedge clk);
    base_addr   = b;
    max_entries = m;
    start       = 1'b1;
    exp_base    = {b[31:3], 3'b000};
    seg_cnt     = 0;
    req_cnt     = 0;
    seg_sum     = '0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R4 walk completes", 64'(done), 64'd1);
  endtask

  task automatic finish_checks(input int nseg, input bit eerr, input string tag);
    int reqs;
    check(err == eerr, {tag, " err flag"}, 64'(err), 64'(eerr));
    check(seg_cnt == nseg, {tag, " segment count"}, 64'(seg_cnt), 64'(nseg));
    check(byte_total == seg_sum, "R8 byte_total", 64'(byte_total), 64'(seg_sum));
    reqs = req_cnt;
    repeat (6) @(negedge clk);
    check(req_cnt == reqs, {tag, " no request after end"}, 64'(req_cnt), 64'(reqs));
    check(done == 1'b1 && err == eerr, "R10 flags hold", {62'd0, done, err}, {62'd1, eerr});
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // list at 0x000: three entries, marker on the third
    for (int i = 0; i < 128; i++) mem[i] = 32'(i) * 32'h0101_0101;
    mem[0]  = 32'h7000_0010; mem[1]  = 32'h8000_1000;
    mem[2]  = 32'h0000_0020; mem[3]  = 32'h0000_2000;
    mem[4]  = 32'h8A00_0030; mem[5]  = 32'hFFFF_FFFC;
    mem[6]  = 32'h0000_0007; mem[7]  = 32'h0000_7000;
    // list at 0x040: single marked entry
    mem[16] = 32'h8000_0100; mem[17] = 32'h9234_5678;
    // list at 0x080: eight entries, none marked
    for (int i = 0; i < 8; i++) begin
      mem[32 + 2*i]     = 32'h1000_0000 | (32'h40 * 32'(i + 1));
      mem[32 + 2*i + 1] = 32'h3000 + 32'h100 * 32'(i);
    end
    // list at 0x100: second entry's address word read fails
    mem[64] = 32'h0000_0044; mem[65] = 32'h0000_5000;
    mem[66] = 32'h8000_0055; mem[67] = 32'h0000_6000;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err, "R1 status idle", {61'd0, busy, done, err}, 64'd0);
    check(!rd_req_valid && !seg_valid, "R1 no valid", {62'd0, rd_req_valid, seg_valid}, 64'd0);
    check(byte_total == 0, "R1 byte_total", 64'(byte_total), 64'd0);

    // table walk
    for (int v = 0; v < 7; v++) begin
      err_addr = (v == 6) ? 32'h10C : 32'hFFFF_FFFF;
      pulse_start(VECS[v].base, VECS[v].maxe);
      wait_done();
      finish_checks(int'(VECS[v].nseg), VECS[v].eerr, $sformatf("R5/R6 vec%0d", v));
    end
    err_addr = 32'hFFFF_FFFF;

    // R3 sum over masked lengths of list at 0x000
    pulse_start(32'h000, 8'd8);
    wait_done();
    check(byte_total == 32'h0A00_0060, "R3 masked total", 64'(byte_total), 64'h0A00_0060);

    // R9 start while busy is ignored
    pulse_start(32'h000, 8'd8);
    repeat (4) @(negedge clk);
    check(busy == 1'b1, "R9 busy during walk", 64'(busy), 64'd1);
    base_addr = 32'h040; max_entries = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    finish_checks(3, 1'b0, "R9 first walk kept");

    // R5 zero limit and R8 clear on start
    check(byte_total != 0, "R8 total before restart", 64'(byte_total), 64'd1);
    pulse_start(32'h000, 8'd0);
    check(done && err, "R5 zero limit ends with error", {62'd0, done, err}, 64'd3);
    check(byte_total == 0, "R8 cleared on start", 64'(byte_total), 64'd0);
    repeat (6) @(negedge clk);
    check(req_cnt == 0, "R5 zero limit issues no read", 64'(req_cnt), 64'd0);

    // R10 start clears done and err
    pulse_start(32'h080, 8'd2);
    check(!done && !err, "R10 flags cleared by start", {62'd0, done, err}, 64'd0);
    wait_done();
    finish_checks(2, 1'b1, "R5 short limit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule